// File: doc/BRIEF.md
# Three-Phase Bridge Gate Controller with Dead Time

This block turns three per-phase drive requests into the six gate controls of a three-phase half-bridge set. Each phase asks for its high transistor, its low transistor, or neither (float). Before the requests reach the legs, a direction bit can exchange the requests of two phases. An enable input and an active-low brake input can then override them. Enable has the higher priority. When it is low, every transistor is off. When the brake is active, every high-side transistor is on and every low-side transistor is off. Only when neither override applies does each leg follow its own request.

Every leg holds its own dead-time counter. A transistor turns on only after both transistors of its leg have been off for `DEAD_CYC` full clock cycles. So when a leg reverses, its conducting transistor turns off first, and the opposite one turns on later. The brake goes through the same guard. The overcurrent and thermal fault flags are registered into an active-low diagnostic output that behaves like an open-drain pull-down. A system can tie that output back to enable. There is no data stream in this block, so every pin is a plain control or status signal with no handshake.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all six gate outputs are 0 and `diag_n` is 1.
- R2: Each phase request is 2 bits. Bits [1:0] are phase 0, [3:2] are phase 1 and [5:4] are phase 2. Code 2'b10 asks for the high gate, 2'b01 asks for the low gate, and 2'b00 and 2'b11 both mean float (both gates off). Gate bit i belongs to leg i.
- R3: In no cycle are the high and low gates of the same leg both 1.
- R4: A float request turns a leg's gates off on the next clock edge. A gate turns on only after both gates of its leg have been 0 for `DEAD_CYC` consecutive cycles. A leg that has already been off that long turns its gate on one edge after the request.
- R5: When `enable` is 0, all six gates are 0 from the next edge on, whatever the brake and the requests say.
- R6: When `enable` is 1 and `brake_n` is 0, all low gates are 0 from the next edge on. Each high gate then turns on under the dead-time rule of R4.
- R7: When `dir_fwd` is 1, phase i drives leg i. When it is 0, phase 0 drives leg 0, phase 1 drives leg 2, and phase 2 drives leg 1.
- R8: `diag_n` is 0 on the cycle after the cycle in which `oc_flag` or `therm_flag` is 1, and 1 otherwise.
- R9: Each leg has its own dead-time counter. A leg that is waiting out its dead time does not delay a turn-on in another leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_req | input | 6 | Three 2-bit phase requests (see R2) |
| enable | input | 1 | 0 forces all gates off |
| brake_n | input | 1 | 0 selects brake: all high sides on |
| dir_fwd | input | 1 | 1 forward, 0 swaps phases 1 and 2 |
| oc_flag | input | 1 | High-side overcurrent detected |
| therm_flag | input | 1 | Thermal fault detected |
| gate_hi | output | 3 | High-side gate per leg |
| gate_lo | output | 3 | Low-side gate per leg |
| diag_n | output | 1 | Active-low fault indication |

## Verification
The collisions that matter most come from the overrides meeting a leg's dead-time countdown. In one case, enable falls in the same cycle that the brake is applied. In another, the brake arrives while a low gate is conducting. The bench drives both overrides at the same falling edge and expects every gate to stay 0 for longer than the dead time. It then applies the brake alone to a leg that is driving low. For that case it checks, cycle by cycle, that the low gate drops on the first edge and that the high gate rises exactly `DEAD_CYC` cycles later. It also checks that a second leg switched in the same cycle turns on at once.

// File: rtl/bridge_gate_pkg.sv
package bridge_gate_pkg;
  localparam int unsigned NUM_LEGS = 3;

  typedef enum logic [1:0] {
    LEG_FLOAT     = 2'b00,
    LEG_LOW       = 2'b01,
    LEG_HIGH      = 2'b10,
    LEG_FLOAT_ALT = 2'b11
  } leg_req_e;
endpackage

// File: rtl/drive_select.sv
module drive_select
  import bridge_gate_pkg::*;
#(
  parameter int unsigned LEGS = NUM_LEGS
) (
  input  logic [2*LEGS-1:0] req_i,
  input  logic              enable_i,
  input  logic              brake_n_i,
  input  logic              fwd_i,
  output logic [2*LEGS-1:0] tgt_o
);
  // Reverse rotation swaps the requests of phases 1 and 2.
  function automatic int unsigned src_of(input int unsigned leg, input logic fwd);
    if (fwd || leg == 0) return leg;
    return (leg == 1) ? 2 : 1;
  endfunction

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    logic [1:0] raw;
    leg_req_e   pick;
    always_comb begin
      raw = req_i[2*src_of(g, fwd_i) +: 2];
      if (!enable_i)       pick = LEG_FLOAT;
      else if (!brake_n_i) pick = LEG_HIGH;
      else begin
        unique case (raw)
          2'b10:   pick = LEG_HIGH;
          2'b01:   pick = LEG_LOW;
          default: pick = LEG_FLOAT;
        endcase
      end
    end
    assign tgt_o[2*g +: 2] = pick;
  end
endmodule

// File: rtl/leg_gate.sv
module leg_gate
  import bridge_gate_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] tgt_i,
  output logic       hi_o,
  output logic       lo_o
);
  localparam int unsigned CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] LIM     = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] GAP_MAX = CW'(DEAD_CYC);

  logic          hi_q, lo_q, hi_d, lo_d;
  logic [CW-1:0] off_cnt;
  logic          ready;
  leg_req_e      tgt;

  assign tgt   = leg_req_e'(tgt_i);
  assign ready = (off_cnt == LIM) && !hi_q && !lo_q;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    unique case (tgt)
      LEG_HIGH: begin
        if (lo_q)               lo_d = 1'b0;
        else if (!hi_q && ready) hi_d = 1'b1;
      end
      LEG_LOW: begin
        if (hi_q)               hi_d = 1'b0;
        else if (!lo_q && ready) lo_d = 1'b1;
      end
      default: begin
        hi_d = 1'b0;
        lo_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
      off_cnt <= LIM;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
      if (hi_q || lo_q)      off_cnt <= '0;
      else if (off_cnt != LIM) off_cnt <= off_cnt + 1'b1;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // Independent count of cycles the leg has spent fully off.
  logic [CW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= GAP_MAX;
    else if (hi_o || lo_o)     gap_q <= '0;
    else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
  end

  AST_LEG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(hi_o && lo_o)); // R3
  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n) ($rose(hi_o) || $rose(lo_o)) |-> gap_q >= GAP_MAX); // R4
  AST_FLOAT_OFF: assert property (@(posedge clk) disable iff (!rst_n) (tgt_i == 2'b00) |=> (!hi_o && !lo_o)); // R4
endmodule

// File: rtl/fault_flag.sv
module fault_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_i,
  input  logic therm_i,
  output logic diag_n_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) diag_n_o <= 1'b1;
    else        diag_n_o <= !(oc_i || therm_i);
  end

  AST_DIAG_PULL: assert property (@(posedge clk) disable iff (!rst_n) (oc_i || therm_i) |=> !diag_n_o); // R8
  AST_DIAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !(oc_i || therm_i) |=> diag_n_o); // R8
endmodule

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl
  import bridge_gate_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 50
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*NUM_LEGS-1:0] phase_req,
  input  logic                  enable,
  input  logic                  brake_n,
  input  logic                  dir_fwd,
  input  logic                  oc_flag,
  input  logic                  therm_flag,
  output logic [NUM_LEGS-1:0]   gate_hi,
  output logic [NUM_LEGS-1:0]   gate_lo,
  output logic                  diag_n
);
  logic [2*NUM_LEGS-1:0] tgt;

  drive_select #(.LEGS(NUM_LEGS)) sel_i (
    .req_i     (phase_req),
    .enable_i  (enable),
    .brake_n_i (brake_n),
    .fwd_i     (dir_fwd),
    .tgt_o     (tgt)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    leg_gate #(.DEAD_CYC(DEAD_CYC)) leg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tgt_i (tgt[2*g +: 2]),
      .hi_o  (gate_hi[g]),
      .lo_o  (gate_lo[g])
    );
  end

  fault_flag diag_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .oc_i     (oc_flag),
    .therm_i  (therm_flag),
    .diag_n_o (diag_n)
  );

  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> (gate_hi == '0 && gate_lo == '0)); // R5
  AST_BRAKE_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n) (enable && !brake_n) |=> gate_lo == '0); // R6
endmodule

// File: tb/bridge_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module bridge_gate_ctrl_tb_top;
  localparam int DT = 4;
  localparam int NV = 10;
  // {enable, brake_n, dir_fwd, phase_req[5:0], exp_hi[2:0], exp_lo[2:0]}
  localparam logic [14:0] VEC [NV] = '{
    {3'b111, 6'b00_01_10, 3'b001, 3'b010},  // R2 forward
    {3'b110, 6'b00_01_10, 3'b001, 3'b100},  // R7 reverse
    {3'b111, 6'b00_10_01, 3'b010, 3'b001},  // R2
    {3'b111, 6'b10_01_00, 3'b100, 3'b010},  // R2
    {3'b110, 6'b10_01_00, 3'b010, 3'b100},  // R7
    {3'b101, 6'b01_01_01, 3'b111, 3'b000},  // R6 brake
    {3'b001, 6'b01_01_01, 3'b000, 3'b000},  // R5 disable over brake
    {3'b011, 6'b10_10_10, 3'b000, 3'b000},  // R5
    {3'b111, 6'b11_11_11, 3'b000, 3'b000},  // R2 alt float
    {3'b111, 6'b01_10_10, 3'b011, 3'b100}   // R2
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] phase_req = '0;
  logic enable = 1'b0, brake_n = 1'b1, dir_fwd = 1'b1, oc_flag = 1'b0, therm_flag = 1'b0;
  logic [2:0] gate_hi, gate_lo;
  logic diag_n;
  int n_run = 0, n_fail = 0, overlap = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bridge_gate_ctrl #(.DEAD_CYC(DT)) dut_i (
    .clk(clk), .rst_n(rst_n), .phase_req(phase_req), .enable(enable),
    .brake_n(brake_n), .dir_fwd(dir_fwd), .oc_flag(oc_flag),
    .therm_flag(therm_flag), .gate_hi(gate_hi), .gate_lo(gate_lo), .diag_n(diag_n)
  );

  always @(negedge clk) if (rst_n && ((gate_hi & gate_lo) != 3'b000)) overlap++;

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual hi/lo/diag=%b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(2);
    chk("R1", {gate_hi, gate_lo, diag_n}, 7'b000_000_1);
    rst_n = 1'b1;
    step(1);
    chk("R1", {gate_hi, gate_lo, diag_n}, 7'b000_000_1);

    for (int v = 0; v < NV; v++) begin
      {enable, brake_n, dir_fwd, phase_req} = VEC[v][14:6];
      step(2 * DT + 2);
      chk($sformatf("R2/R5/R6/R7 vec%0d", v), {gate_hi, gate_lo, 1'b1}, {VEC[v][5:0], 1'b1});
    end

    // R4 / R9: leg0 low -> high while leg1 float -> high
    {enable, brake_n, dir_fwd, phase_req} = {3'b111, 6'b00_00_01};
    step(2 * DT + 2);
    phase_req = 6'b00_10_10;
    step(1);
    chk("R4 low drops first", {gate_hi, gate_lo, 1'b1}, {3'b010, 3'b000, 1'b1});
    chk("R9 other leg immediate", {2'b00, gate_hi[1], 4'b0}, {2'b00, 1'b1, 4'b0});
    step(DT - 1);
    chk("R4 still in dead time", {gate_hi, gate_lo, 1'b1}, {3'b010, 3'b000, 1'b1});
    step(1);
    chk("R4 high after dead time", {gate_hi, gate_lo, 1'b1}, {3'b011, 3'b000, 1'b1});

    // R6: brake on a conducting low side passes through dead time
    phase_req = 6'b00_00_01;
    step(2 * DT + 2);
    brake_n = 1'b0;
    step(1);
    chk("R6 low off on first edge", {gate_hi, gate_lo, 1'b1}, {3'b110, 3'b000, 1'b1});
    step(DT - 1);
    chk("R6 high held in dead time", {gate_hi, gate_lo, 1'b1}, {3'b110, 3'b000, 1'b1});
    step(1);
    chk("R6 high after dead time", {gate_hi, gate_lo, 1'b1}, {3'b111, 3'b000, 1'b1});

    // R5: disable and brake in the same cycle from all-low
    {enable, brake_n, phase_req} = {2'b11, 6'b01_01_01};
    step(2 * DT + 2);
    {enable, brake_n} = 2'b00;
    step(1);
    chk("R5 off with brake", {gate_hi, gate_lo, 1'b1}, 7'b000_000_1);
    step(DT + 3);
    chk("R5 stays off", {gate_hi, gate_lo, 1'b1}, 7'b000_000_1);
    {enable, brake_n, phase_req} = {2'b11, 6'b10_10_10};
    step(1);
    chk("R4 ready leg turns on next edge", {gate_hi, gate_lo, 1'b1}, 7'b111_000_1);

    // R8 diagnostic
    oc_flag = 1'b1;
    step(1);
    chk("R8 overcurrent", {6'b0, diag_n}, 7'b0);
    oc_flag = 1'b0;
    step(1);
    chk("R8 release", {6'b0, diag_n}, 7'b1);
    therm_flag = 1'b1;
    step(1);
    chk("R8 thermal", {6'b0, diag_n}, 7'b0);
    therm_flag = 1'b0;
    step(1);
    chk("R8 release thermal", {6'b0, diag_n}, 7'b1);

    chk("R3 no overlap seen", 7'(overlap), 7'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule